// File: doc/BRIEF.md
# Error Interrupt Hub with Raw and Gated Status

This block gathers single-cycle error pulses from a memory controller and turns them into one level-sensitive interrupt line. Four sources feed it: a command or address error, a write made against the ECC granule alignment, an uncorrectable two-bit ECC error, and a single-bit ECC error count reaching its threshold. Each source owns a fixed bit in every register. Bit 0 is the command/address error, bit 3 is the write-alignment error, bit 4 is the two-bit error, and bit 5 is the one-bit threshold event. Bits 1, 2, 6 and 7 are reserved.

Each source has two status flags. The raw flag is always captured. The gated flag is captured only while the source is enabled. Software changes the enable mask through two addresses: one sets enable bits and one clears them. Writing ones to the gated status clears a source. Writing ones to the raw status makes a forced event, which is useful for testing interrupt handlers. A plain register port gives access. A write takes effect at the clock edge where `reg_we` is high. Read data comes from a register and shows the addressed register one cycle after the address is applied.

Register addresses: 0 is raw status, 1 is gated status, 2 is enable-set, and 3 is enable-clear.

Top module: `err_irq_hub`

## Requirements
- R1: After reset, raw status, gated status and the enable mask all read 0, and `irq` is 0.
- R2: A write to address 2 sets every enable bit where the write data has a 1. Bits written 0 keep their value. Addresses 2 and 3 both read back the current enable mask.
- R3: A write to address 3 clears every enable bit where the write data has a 1. Bits written 0 keep their value.
- R4: A pulse on `src_evt[k]` sets the raw bit of that source whether or not the source is enabled. Index 0 maps to bit 0, 1 to bit 3, 2 to bit 4 and 3 to bit 5.
- R5: An event sets the gated bit only if that source was enabled in the cycle of the event.
- R6: Writing 1 to a bit at address 1 clears both the gated bit and the raw bit of that source. This also works while the source is disabled.
- R7: Writing 1 to a bit at address 0 counts as an event on that source. It sets the raw bit, and it also sets the gated bit when the source is enabled. Writing 0 at address 0 clears nothing.
- R8: `irq` is 1 exactly when some source has both its raw bit and its enable bit set. It changes at the same clock edge as the state that causes it, and it stays high until a clear or a disable removes the cause.
- R9: If an event, or a forced event, and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R10: Reserved bits 1, 2, 6 and 7 always read 0 at every address and ignore writes.
- R11: `reg_rdata` shows the register selected by `reg_addr` one clock edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | 4 | Single-cycle event pulses, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is an event pulse that lands in the same cycle as a write-one-to-clear of the same bit, with that bit already set. Only in this case does the set-wins rule show up. The bench gets there with a write task that can also raise an event in its write cycle, and then reads both status registers back. It also clears a source while that source is disabled. Before doing so, it checks that `irq` has dropped even though the status bits are still set.

// File: rtl/err_irq_hub_pkg.sv
package err_irq_hub_pkg;
  localparam int NUM_SRC = 4;
  localparam int REG_W   = 8;
  localparam int ADR_W   = 2;

  localparam logic [ADR_W-1:0] A_RAW  = 2'd0;
  localparam logic [ADR_W-1:0] A_GATE = 2'd1;
  localparam logic [ADR_W-1:0] A_ESET = 2'd2;
  localparam logic [ADR_W-1:0] A_ECLR = 2'd3;

  // register bit owned by each source; other decoders rely on these positions
  function automatic int src_bit(input int s);
    case (s)
      0: return 0;
      1: return 3;
      2: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] live_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int s = 0; s < NUM_SRC; s++) m[src_bit(s)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] LIVE = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q,
  output logic [W-1:0] en_nxt
);
  always_comb begin
    en_nxt = en_q;
    if (set_we) en_nxt = en_nxt | wdata;
    if (clr_we) en_nxt = en_nxt & ~wdata;
    en_nxt = en_nxt & LIVE;
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_nxt;
  end

  for (genvar b = 0; b < W; b++) begin : g_chk
    if (LIVE[b]) begin : g_live
      p_en_set_r2: assert property (@(posedge clk) disable iff (rst)
        (set_we && wdata[b]) |=> en_q[b]);
      p_en_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (clr_we && wdata[b]) |=> !en_q[b]);
    end
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int W = 8,
  parameter logic [W-1:0] LIVE = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] hw_evt,
  input  logic         force_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] en_q,
  output logic [W-1:0] raw_q,
  output logic [W-1:0] gate_q,
  output logic [W-1:0] raw_nxt
);
  logic [W-1:0] gate_nxt;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic hit, wipe;
    assign hit  = hw_evt[b] | (force_we & wdata[b]);
    assign wipe = clr_we & wdata[b];

    always_comb begin
      raw_nxt[b]  = LIVE[b] & (hit | (raw_q[b] & ~wipe));
      gate_nxt[b] = LIVE[b] & ((hit & en_q[b]) | (gate_q[b] & ~wipe));
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        raw_q[b]  <= 1'b0;
        gate_q[b] <= 1'b0;
      end else begin
        raw_q[b]  <= raw_nxt[b];
        gate_q[b] <= gate_nxt[b];
      end
    end

    if (LIVE[b]) begin : g_chk
      p_raw_capture_r4: assert property (@(posedge clk) disable iff (rst)
        hw_evt[b] |=> raw_q[b]);
      p_gate_blocked_r5: assert property (@(posedge clk) disable iff (rst)
        (!gate_q[b] && hw_evt[b] && !en_q[b] && !(force_we && wdata[b])) |=> !gate_q[b]);
      p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_we && wdata[b] && !hw_evt[b]) |=> (!raw_q[b] && !gate_q[b]));
      p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (clr_we && wdata[b] && hw_evt[b] && en_q[b]) |=> (raw_q[b] && gate_q[b]));
    end
  end
endmodule

// File: rtl/err_irq_hub.sv
module err_irq_hub
  import err_irq_hub_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int DW    = REG_W,
  parameter int AW    = ADR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N_SRC-1:0] src_evt,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  localparam logic [DW-1:0] LIVE = DW'(live_mask());

  logic [DW-1:0] hw_vec, raw_q, gate_q, raw_nxt, en_q, en_nxt;
  logic          wr_raw, wr_gate, wr_eset, wr_eclr;

  assign wr_raw  = reg_we && (reg_addr == AW'(A_RAW));
  assign wr_gate = reg_we && (reg_addr == AW'(A_GATE));
  assign wr_eset = reg_we && (reg_addr == AW'(A_ESET));
  assign wr_eclr = reg_we && (reg_addr == AW'(A_ECLR));

  always_comb begin
    hw_vec = '0;
    for (int s = 0; s < N_SRC; s++) hw_vec[src_bit(s)] = src_evt[s];
  end

  irq_enable_reg #(.W(DW), .LIVE(LIVE)) u_en (
    .clk(clk), .rst(rst), .set_we(wr_eset), .clr_we(wr_eclr),
    .wdata(reg_wdata), .en_q(en_q), .en_nxt(en_nxt)
  );

  irq_status_bank #(.W(DW), .LIVE(LIVE)) u_stat (
    .clk(clk), .rst(rst), .hw_evt(hw_vec), .force_we(wr_raw),
    .clr_we(wr_gate), .wdata(reg_wdata), .en_q(en_q),
    .raw_q(raw_q), .gate_q(gate_q), .raw_nxt(raw_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      irq <= |(raw_nxt & en_nxt);
      case (reg_addr)
        AW'(A_RAW):  reg_rdata <= raw_q;
        AW'(A_GATE): reg_rdata <= gate_q;
        default:     reg_rdata <= en_q;
      endcase
    end
  end

  p_irq_level_r8: assert property (@(posedge clk) disable iff (rst)
    irq == |(raw_q & en_q));
  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & ~LIVE) == '0);
endmodule

// File: tb/err_irq_hub_bench.sv
`timescale 1ns/1ps
module err_irq_hub_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] src_evt = '0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;
  logic       rd_req = 1'b0;
  int checks = 0;
  int errors = 0;

  typedef struct { logic [7:0] exp; string tag; } sb_item_t;
  sb_item_t sb[$];

  always #2.5 clk = ~clk;

  err_irq_hub u_err_irq_hub (
    .clk(clk), .rst(rst), .src_evt(src_evt), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // monitor: pops expected read data, R11 one-edge latency
  always begin
    @(posedge clk);
    if (rd_req) begin
      sb_item_t it;
      #1;
      it = sb.pop_front();
      checks++;
      if (reg_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: rdata=%h expected %h", it.tag, reg_rdata, it.exp);
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    sb.push_back('{e, tag});
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [3:0] ev);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; src_evt = ev;
    @(negedge clk);
    reg_we = 1'b0; src_evt = '0;
  endtask

  task automatic pulse(input logic [3:0] ev);
    @(negedge clk);
    src_evt = ev;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq=%b expected %b", tag, irq, e);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(2'd0, 8'h00, "R1 raw reset");
    rd(2'd1, 8'h00, "R1 gated reset");
    rd(2'd2, 8'h00, "R1 enable reset");
    // R4/R5 event while disabled
    pulse(4'b0001);
    chk_irq(1'b0, "R8 no irq while disabled");
    rd(2'd0, 8'h01, "R4 raw set while disabled");
    rd(2'd1, 8'h00, "R5 gated not set while disabled");
    // R2/R10 enable with reserved bits written
    wr(2'd2, 8'hFF, 4'b0000);
    chk_irq(1'b1, "R8 enabling pending raw raises irq");
    rd(2'd2, 8'h39, "R2 R10 enable readback at set address");
    rd(2'd3, 8'h39, "R2 enable readback at clear address");
    rd(2'd1, 8'h00, "R5 gated stays clear after late enable");
    // R6 clear
    wr(2'd1, 8'h01, 4'b0000);
    chk_irq(1'b0, "R6 irq drops after clear");
    rd(2'd0, 8'h00, "R6 raw cleared by gated write");
    // R4/R5 enabled event, index 2 -> bit 4
    pulse(4'b0100);
    chk_irq(1'b1, "R8 irq on enabled event");
    rd(2'd1, 8'h10, "R5 gated bit 4 set");
    // R3 disable
    wr(2'd3, 8'h10, 4'b0000);
    chk_irq(1'b0, "R3 R8 irq drops on disable");
    rd(2'd2, 8'h29, "R3 enable bit 4 cleared");
    wr(2'd2, 8'h00, 4'b0000);
    wr(2'd3, 8'h00, 4'b0000);
    rd(2'd3, 8'h29, "R2 R3 zero writes ignored");
    rd(2'd0, 8'h10, "R8 raw held after disable");
    // R6 clear while disabled
    wr(2'd1, 8'h10, 4'b0000);
    rd(2'd0, 8'h00, "R6 raw cleared while disabled");
    rd(2'd1, 8'h00, "R6 gated cleared while disabled");
    // R7 forced event
    wr(2'd0, 8'h20, 4'b0000);
    chk_irq(1'b1, "R7 forced raw raises irq");
    rd(2'd1, 8'h20, "R7 forced event sets gated");
    wr(2'd0, 8'h00, 4'b0000);
    wr(2'd0, 8'h06, 4'b0000);
    rd(2'd0, 8'h20, "R7 R10 zero and reserved raw writes");
    // R9 set wins over clear
    wr(2'd1, 8'h20, 4'b1000);
    chk_irq(1'b1, "R9 irq kept");
    rd(2'd0, 8'h20, "R9 raw kept");
    rd(2'd1, 8'h20, "R9 gated kept");
    wr(2'd1, 8'h20, 4'b0000);
    chk_irq(1'b0, "R6 irq cleared");
    // two sources at once, index 0 and 1 -> bits 0 and 3
    pulse(4'b0011);
    rd(2'd0, 8'h09, "R4 two raw bits");
    wr(2'd1, 8'h01, 4'b0000);
    chk_irq(1'b1, "R8 irq held by other source");
    wr(2'd1, 8'h08, 4'b0000);
    chk_irq(1'b0, "R8 irq drops after last clear");
    rd(2'd1, 8'h00, "R6 gated empty");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule